// File: doc/BRIEF.md
# Memory Error Report Log with Interrupt Triggers

This block gathers memory error reports from the error detectors of a memory subsystem. Each report carries an error kind (corrected, uncorrectable, or poisoned data that was consumed), the bank and RAM instance that saw the error, and the failing address. Every accepted report goes into an in-order queue. Software drains the queue through a valid/ready read port. The bank and RAM fields together locate the replaceable unit at fault.

A single interrupt line tells software that the log needs attention. Three independent causes can raise it, and each has its own sticky bit. The first is the queue filling to three quarters of its depth. The second is the logging of an error whose kind software has selected with a mask. The third is the head entry waiting longer than a programmable number of cycles. Error detectors cannot be stalled, so the report port has no ready signal. A report that arrives while the queue is full is discarded, and a saturating counter records the loss, so the loss is never silent. The read port follows the usual valid/ready rules: an entry leaves only in a cycle where both `log_valid` and `log_ready` are high. `log_ready` may be held high at any time, and it has no effect while the queue is empty.

Top module: `errlog_top`

## Requirements
- R1: After reset the log is empty: `fill_level` is 0, `log_valid` is 0, `irq_cause` is 0, `irq` is 0 and `ovf_count` is 0.
- R2: Accepted reports leave the read port in arrival order, and kind, bank, RAM and address are unchanged.
- R3: `log_valid` is high exactly when `fill_level` is non-zero. An entry is removed on a clock edge where `log_valid` and `log_ready` are both high. `log_ready` while empty changes nothing.
- R4: A report presented while `fill_level` equals DEPTH is discarded, even if a pop happens in the same cycle. The stored entries stay as they were, and `ovf_count` rises by one, saturating at 2^OVF_W-1.
- R5: `ovf_clear` sets `ovf_count` to 0 on the next edge. It takes priority over a discard in the same cycle.
- R6: `irq_cause[0]` (fill) becomes 1 one cycle after `fill_level` is at least ceil(3*DEPTH/4). With DEPTH 8 this is a level of 6.
- R7: `irq_cause[1]` (kind) becomes 1 on the edge that accepts a report whose kind bit is set in `cfg_kind_mask`. Kind codes are 0 corrected, 1 uncorrectable and 2 poison consumed, and mask bit i selects kind i. Code 3 never matches, and discarded reports never set this bit.
- R8: An age count restarts at 0 whenever the log is empty or the head is popped. Otherwise it grows by one per cycle. `irq_cause[2]` (age) becomes 1 on an edge where the log is non-empty, no pop occurs, and the count has reached `cfg_age_limit`.
- R9: Cause bits stay set until software writes a 1 to the matching `cause_clear` bit. A cause that is raised again in the same cycle wins over the clear. `irq` is the OR of the cause bits.
- R10: A push and a pop in the same cycle on a non-full log leave `fill_level` unchanged, and the next entry moves to the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpt_valid | input | 1 | Error report present this cycle |
| rpt_kind | input | 2 | Error kind code |
| rpt_bank | input | BANK_W | Bank of the failing location |
| rpt_ram | input | RAM_W | RAM instance within the bank |
| rpt_addr | input | ADDR_W | Failing address |
| log_valid | output | 1 | Head entry available |
| log_ready | input | 1 | Software takes the head entry |
| log_kind | output | 2 | Head entry kind |
| log_bank | output | BANK_W | Head entry bank |
| log_ram | output | RAM_W | Head entry RAM instance |
| log_addr | output | ADDR_W | Head entry address |
| fill_level | output | LVL_W | Number of stored entries |
| cfg_kind_mask | input | 3 | Kinds that raise the kind cause |
| cfg_age_limit | input | AGE_W | Head age limit in cycles |
| cause_clear | input | 3 | Write-one-to-clear for the cause bits |
| irq_cause | output | 3 | Sticky causes: bit 0 fill, bit 1 kind, bit 2 age |
| irq | output | 1 | Interrupt request |
| ovf_count | output | OVF_W | Discarded report count |
| ovf_clear | input | 1 | Zero the discard count |

## Verification
The assertions assume that `rpt_kind` never carries the reserved code 3. They also assume that the configuration inputs are steady whenever a check relies on them, because the checker treats the mask and the age limit as current-cycle values. The stimulus drives only kinds 0 to 2. It changes `cfg_kind_mask` and `cfg_age_limit` only while reset is held, and drives all inputs one time unit after the rising edge, so every input is stable across the edge that samples it.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  localparam int NUM_KINDS  = 3;
  localparam int NUM_CAUSES = 3;
  localparam int KIND_W     = 2;

  typedef enum logic [KIND_W-1:0] {
    EK_CORRECTED = 2'd0,
    EK_UNCORR    = 2'd1,
    EK_POISON    = 2'd2,
    EK_RESERVED  = 2'd3
  } err_kind_e;

  localparam int CZ_FILL = 0;
  localparam int CZ_KIND = 1;
  localparam int CZ_AGE  = 2;
endpackage

// File: rtl/errlog_store.sv
module errlog_store #(
  parameter int DEPTH = 8,
  parameter int W     = 41,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign level   = count;
  assign full    = (count == LVL_W'(DEPTH));
  assign empty   = (count == '0);
endmodule

// File: rtl/errlog_age.sv
module errlog_age #(
  parameter int AGE_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             occupied,
  input  logic             head_pop,
  input  logic [AGE_W-1:0] limit,
  output logic             expired
);
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (!occupied || head_pop) begin
      age_q <= '0;
    end else if (age_q != '1) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign expired = occupied && !head_pop && (age_q >= limit);
endmodule

// File: rtl/errlog_ovf.sv
module errlog_ovf #(
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  input  logic             clear,
  output logic [OVF_W-1:0] count
);
  logic [OVF_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (drop && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/errlog_irq.sv
module errlog_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] cause,
  output logic         irq
);
  logic [N-1:0] cause_q;

  for (genvar i = 0; i < N; i++) begin : g_cause
    always_ff @(posedge clk) begin
      if (!rst_n)      cause_q[i] <= 1'b0;
      else if (set[i]) cause_q[i] <= 1'b1;
      else if (clr[i]) cause_q[i] <= 1'b0;
    end
  end

  assign cause = cause_q;
  assign irq   = |cause_q;
endmodule

// File: rtl/errlog_top.sv
module errlog_top
  import errlog_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int RAM_W  = 4,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 28,
  parameter int OVF_W  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rpt_valid,
  input  logic [1:0]        rpt_kind,
  input  logic [BANK_W-1:0] rpt_bank,
  input  logic [RAM_W-1:0]  rpt_ram,
  input  logic [ADDR_W-1:0] rpt_addr,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [1:0]        log_kind,
  output logic [BANK_W-1:0] log_bank,
  output logic [RAM_W-1:0]  log_ram,
  output logic [ADDR_W-1:0] log_addr,
  output logic [LVL_W-1:0]  fill_level,
  input  logic [2:0]        cfg_kind_mask,
  input  logic [AGE_W-1:0]  cfg_age_limit,
  input  logic [2:0]        cause_clear,
  output logic [2:0]        irq_cause,
  output logic              irq,
  output logic [OVF_W-1:0]  ovf_count,
  input  logic              ovf_clear
);
  localparam int ENTRY_W = KIND_W + BANK_W + RAM_W + ADDR_W;
  localparam int THR     = (3 * DEPTH + 3) / 4;

  logic               full, empty, push_ok, pop_ok, drop, kind_hit, aged;
  logic [ENTRY_W-1:0] wr_entry, rd_entry;
  logic [NUM_CAUSES-1:0] cause_set;

  assign push_ok  = rpt_valid && !full;
  assign drop     = rpt_valid && full;
  assign pop_ok   = log_valid && log_ready;
  assign wr_entry = {rpt_kind, rpt_bank, rpt_ram, rpt_addr};

  errlog_store #(.DEPTH(DEPTH), .W(ENTRY_W), .LVL_W(LVL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(wr_entry),
    .rd_en(pop_ok), .rd_data(rd_entry), .level(fill_level),
    .full(full), .empty(empty)
  );

  assign log_valid = !empty;
  assign {log_kind, log_bank, log_ram, log_addr} = rd_entry;

  errlog_age #(.AGE_W(AGE_W)) u_age (
    .clk(clk), .rst_n(rst_n), .occupied(!empty), .head_pop(pop_ok),
    .limit(cfg_age_limit), .expired(aged)
  );

  errlog_ovf #(.OVF_W(OVF_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .drop(drop), .clear(ovf_clear), .count(ovf_count)
  );

  always_comb begin
    kind_hit = 1'b0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (rpt_kind == KIND_W'(k) && cfg_kind_mask[k]) kind_hit = 1'b1;
    end
  end

  always_comb begin
    cause_set          = '0;
    cause_set[CZ_FILL] = (fill_level >= LVL_W'(THR));
    cause_set[CZ_KIND] = push_ok && kind_hit;
    cause_set[CZ_AGE]  = aged;
  end

  errlog_irq #(.N(NUM_CAUSES)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(cause_set), .clr(cause_clear),
    .cause(irq_cause), .irq(irq)
  );
endmodule

// File: rtl/errlog_chk.sv
module errlog_chk #(
  parameter int DEPTH  = 8,
  parameter int OVF_W  = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rpt_valid,
  input logic [1:0]       rpt_kind,
  input logic             log_valid,
  input logic             log_ready,
  input logic [LVL_W-1:0] fill_level,
  input logic [2:0]       cfg_kind_mask,
  input logic [2:0]       cause_clear,
  input logic [2:0]       irq_cause,
  input logic             irq,
  input logic [OVF_W-1:0] ovf_count,
  input logic             ovf_clear
);
  localparam int THR = (3 * DEPTH + 3) / 4;

  logic is_full, push_ok, pop_ok, sel_hit;
  assign is_full = (fill_level == LVL_W'(DEPTH));
  assign push_ok = rpt_valid && !is_full;
  assign pop_ok  = log_valid && log_ready;
  assign sel_hit = (rpt_kind != 2'd3) && cfg_kind_mask[rpt_kind];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH)); // R3
  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> !log_valid); // R3
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, fill_level} == ({1'b0, $past(fill_level)}
      + {{LVL_W{1'b0}}, $past(push_ok)} - {{LVL_W{1'b0}}, $past(pop_ok)}))); // R10
  AST_DROP_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && is_full && !ovf_clear && (ovf_count != '1))
      |=> ovf_count == $past(ovf_count) + 1'b1); // R4
  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> ovf_count == '0); // R5
  AST_FILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level >= LVL_W'(THR)) |=> irq_cause[0]); // R6
  AST_KIND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && sel_hit) |=> irq_cause[1]); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_cause) & ~$past(cause_clear)) & ~irq_cause) == 3'b000)); // R9
  AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_cause != 3'b000)); // R9
endmodule

bind errlog_top errlog_chk #(.DEPTH(DEPTH), .OVF_W(OVF_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_kind(rpt_kind),
  .log_valid(log_valid), .log_ready(log_ready), .fill_level(fill_level),
  .cfg_kind_mask(cfg_kind_mask), .cause_clear(cause_clear),
  .irq_cause(irq_cause), .irq(irq), .ovf_count(ovf_count), .ovf_clear(ovf_clear)
);

// File: tb/errlog_top_bench.sv
`timescale 1ns/1ps
module errlog_top_bench;
  localparam int DEPTH = 8, BANK_W = 3, RAM_W = 4, ADDR_W = 32, AGE_W = 28, OVF_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int VW = 1 + 2 + BANK_W + RAM_W + ADDR_W;
  localparam int NV = 8;
  // {expected kind cause with mask 3'b110, kind, bank, ram, addr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'd1, 4'd2,  32'h0000_1000},
    {1'b1, 2'd1, 3'd7, 4'd15, 32'hDEAD_BEEF},
    {1'b1, 2'd2, 3'd0, 4'd0,  32'h0000_0004},
    {1'b0, 2'd0, 3'd5, 4'd9,  32'hFFFF_FFFC},
    {1'b1, 2'd1, 3'd3, 4'd1,  32'h1234_5678},
    {1'b0, 2'd0, 3'd2, 4'd12, 32'h8000_0000},
    {1'b1, 2'd2, 3'd6, 4'd7,  32'h0BAD_F00D},
    {1'b1, 2'd1, 3'd4, 4'd3,  32'h0000_0000}
  };

  logic clk = 0, rst_n = 0;
  logic rpt_valid = 0, log_ready = 0, ovf_clear = 0;
  logic [1:0] rpt_kind = 0;
  logic [BANK_W-1:0] rpt_bank = 0;
  logic [RAM_W-1:0] rpt_ram = 0;
  logic [ADDR_W-1:0] rpt_addr = 0;
  logic [2:0] cfg_kind_mask = 3'b110, cause_clear = 0;
  logic [AGE_W-1:0] cfg_age_limit = 28'd1000;
  logic log_valid, irq;
  logic [1:0] log_kind;
  logic [BANK_W-1:0] log_bank;
  logic [RAM_W-1:0] log_ram;
  logic [ADDR_W-1:0] log_addr;
  logic [LVL_W-1:0] fill_level;
  logic [2:0] irq_cause;
  logic [OVF_W-1:0] ovf_count;
  int n_vec = 0, n_bad = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  errlog_top #(.DEPTH(DEPTH), .BANK_W(BANK_W), .RAM_W(RAM_W), .ADDR_W(ADDR_W),
               .AGE_W(AGE_W), .OVF_W(OVF_W)) u_errlog_top (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; rpt_valid = 0; log_ready = 0; ovf_clear = 0; cause_clear = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic push(logic [1:0] k, logic [BANK_W-1:0] b, logic [RAM_W-1:0] r,
                      logic [ADDR_W-1:0] a);
    rpt_kind = k; rpt_bank = b; rpt_ram = r; rpt_addr = a; rpt_valid = 1;
    tick();
    rpt_valid = 0;
  endtask

  task automatic pop_expect(string req, logic [ADDR_W-1:0] a);
    chk(req, {63'd0, log_valid}, 64'd1);
    chk(req, {32'd0, log_addr}, {32'd0, a});
    log_ready = 1; tick(); log_ready = 0;
  endtask

  task automatic clear_causes(logic [2:0] m);
    cause_clear = m; tick(); cause_clear = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 level", 64'(fill_level), 64'd0);
    chk("R1 valid", 64'(log_valid), 64'd0);
    chk("R1 cause", 64'(irq_cause), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 ovf", 64'(ovf_count), 64'd0);

    // Table walk: R2 field integrity, R7 kind selection
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      clear_causes(3'b111);
      push(v[VW-2 -: 2], v[ADDR_W+RAM_W +: BANK_W], v[ADDR_W +: RAM_W], v[ADDR_W-1:0]);
      chk("R7 kind cause", 64'(irq_cause[1]), 64'(v[VW-1]));
      chk("R3 level one", 64'(fill_level), 64'd1);
      chk("R2 kind", 64'(log_kind), 64'(v[VW-2 -: 2]));
      chk("R2 bank", 64'(log_bank), 64'(v[ADDR_W+RAM_W +: BANK_W]));
      chk("R2 ram", 64'(log_ram), 64'(v[ADDR_W +: RAM_W]));
      pop_expect("R2 addr", v[ADDR_W-1:0]);
      chk("R3 level zero", 64'(fill_level), 64'd0);
    end

    // Fill threshold, overflow, clear priority
    cfg_kind_mask = 3'b111;
    do_reset();
    for (int i = 0; i < 5; i++) push(2'd0, 3'd0, 4'd0, 32'(16 + i));
    tick();
    chk("R6 below threshold", 64'(irq_cause[0]), 64'd0);
    push(2'd0, 3'd0, 4'd0, 32'd21);
    chk("R6 not before next edge", 64'(irq_cause[0]), 64'd0);
    tick();
    chk("R6 threshold cause", 64'(irq_cause[0]), 64'd1);
    push(2'd0, 3'd0, 4'd0, 32'd22);
    push(2'd0, 3'd0, 4'd0, 32'd23);
    clear_causes(3'b010);
    push(2'd1, 3'd0, 4'd0, 32'd100);
    chk("R4 ovf one", 64'(ovf_count), 64'd1);
    chk("R4 level held", 64'(fill_level), 64'd8);
    chk("R7 drop no kind cause", 64'(irq_cause[1]), 64'd0);
    rpt_valid = 1; log_ready = 1; tick(); log_ready = 0; rpt_valid = 0;
    chk("R4 drop with pop", 64'(ovf_count), 64'd2);
    chk("R4 pop level", 64'(fill_level), 64'd7);
    push(2'd0, 3'd0, 4'd0, 32'd24);
    chk("R4 refilled", 64'(fill_level), 64'd8);
    ovf_clear = 1; push(2'd0, 3'd0, 4'd0, 32'd101); ovf_clear = 0;
    chk("R5 clear wins", 64'(ovf_count), 64'd0);
    clear_causes(3'b001);
    chk("R9 set wins over clear", 64'(irq_cause[0]), 64'd1);
    chk("R9 irq", 64'(irq), 64'd1);
    rpt_valid = 1; repeat (260) tick(); rpt_valid = 0;
    chk("R4 saturate", 64'(ovf_count), 64'd255);
    ovf_clear = 1; tick(); ovf_clear = 0;
    chk("R5 clear", 64'(ovf_count), 64'd0);
    for (int i = 1; i < 8; i++) pop_expect("R4 contents kept", 32'(16 + i));
    pop_expect("R4 last", 32'd24);
    chk("R3 empty valid", 64'(log_valid), 64'd0);
    log_ready = 1; tick(); log_ready = 0;
    chk("R3 pop on empty", 64'(fill_level), 64'd0);
    clear_causes(3'b111);
    chk("R9 cleared", 64'(irq_cause), 64'd0);
    chk("R9 irq low", 64'(irq), 64'd0);

    // R10 push and pop together
    push(2'd0, 3'd0, 4'd0, 32'd40);
    push(2'd0, 3'd0, 4'd0, 32'd41);
    push(2'd0, 3'd0, 4'd0, 32'd42);
    chk("R10 head", 64'(log_addr), 64'd40);
    rpt_addr = 32'd43; rpt_valid = 1; log_ready = 1; tick(); rpt_valid = 0; log_ready = 0;
    chk("R10 level", 64'(fill_level), 64'd3);
    pop_expect("R10 order", 32'd41);
    pop_expect("R10 order", 32'd42);
    pop_expect("R10 order", 32'd43);

    // R8 age timeout, limit 10
    cfg_age_limit = 28'd10;
    do_reset();
    push(2'd0, 3'd0, 4'd0, 32'd50);
    push(2'd0, 3'd0, 4'd0, 32'd51);
    repeat (5) tick();
    chk("R8 young head", 64'(irq_cause[2]), 64'd0);
    pop_expect("R8 pop", 32'd50);
    repeat (8) tick();
    chk("R8 age restarted", 64'(irq_cause[2]), 64'd0);
    repeat (5) tick();
    chk("R8 aged", 64'(irq_cause[2]), 64'd1);
    chk("R8 irq", 64'(irq), 64'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule